// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Timer

A 12-bit up-counter, advanced by a clock-enable input, drives four output channels. At its top value (0xFFF) it wraps back to a software-set reload value, which makes the PWM period `0x1000 - reload` counts. Each channel compares the counter against a duty value and applies a polarity bit. The comparators read shadow copies of the duty and polarity settings, not the registers that software writes. Software stages new settings and then sets a transfer-enable bit. At the next wrap, hardware copies all of them into the shadows in the same cycle and clears the bit. Until that wrap, the outputs keep running on the old settings.

A break input, once it is enabled, overrides all four outputs with a stored 4-bit pattern. The break state is sticky: it stays active until software clears it. A single capture input records the counter value on a selectable edge. It refuses any new capture while its flag is still pending. All access goes through a flat 16-bit register port. Writes take effect on the clock edge. Reads are combinational from `addr`.

Top module: `pwm4_shadow_timer`

## Requirements
- R1: The counter (read-only at address 5) resets to 0. It holds while `cnt_en` is 0. With `cnt_en` at 1 it adds one per clock, and at 0xFFF it loads the reload register (address 1, bits 11:0) instead. That wrap sets the overflow flag, status bit 0 at address 4, which is cleared by writing 1 to it.
- R2: The duty registers sit at addresses 8 to 11 for channels 0 to 3 and store bits 11:0. Bits 15:12 always read as 0.
- R3: When output-enable bit i of the control register (address 0, bits 3:0) is 1, `pwm_out[i]` is (counter < shadow duty i) XOR shadow polarity i.
- R4: When that output-enable bit is 0, `pwm_out[i]` is (counter == shadow duty i) XOR shadow polarity i.
- R5: The transfer-enable bit is bit 0 of address 2 and resets to 1. When the counter wraps while the bit is 1, all duty registers and the polarity bits (address 0, bits 7:4) are copied to their shadows, and the bit clears.
- R6: While the transfer-enable bit is 0, a wrap leaves the shadows unchanged, so writes to duty or polarity do not change the outputs.
- R7: When break enable (address 3, bit 4) is set and the break input is seen high after a two-flop synchronizer, break becomes active (address 3, bit 5). While break is active, `pwm_out` equals the pattern in address 3, bits 3:0. Break stays active after the input falls, until software writes 1 to bit 5.
- R8: With break enable at 0, the break input has no effect on `pwm_out` or on the break-active bit.
- R9: After a two-flop synchronizer, an edge on `cap_in` loads the counter into the capture register (address 6) and sets the capture flag (address 4, bit 1). The edge is rising when control bit 8 is 0 and falling when it is 1.
- R10: While the capture flag is set, edges do not change the capture register. Writing 1 to the flag clears it and re-arms capture.
- R11: After reset, `pwm_out` follows R4 with all shadows at 0, and the transfer-enable bit reads 1. The duty registers, capture register, break pattern and break enable all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| brk_in | input | 1 | Asynchronous break request |
| cap_in | input | 1 | Asynchronous capture pin |
| pwm_out | output | 4 | Channel outputs |

## Verification
The bench aims at the wrap cycle. A design that moved the shadows one count late, or moved them without the transfer bit, would show old duty values in the first counts of the new period. A design that forgot to clear the bit would pick up staged values one period too early. The bench also holds break high with break disabled, which catches a break path that is not gated. It then drops the break input after break has fired, which catches a break state that is not sticky. For capture, it sends a second edge while the flag is pending; a design that overwrote the register would show the newer count. It also drives the falling-edge mode, where a detector with the wrong polarity captures nothing.

// File: rtl/pwm4_shadow_timer.sv
module pwm4_shadow_timer #(
  parameter int CW  = 12,
  parameter int DW  = 16,
  parameter int NCH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          brk_in,
  input  logic          cap_in,
  output logic [3:0]    pwm_out
);
  localparam logic [CW-1:0] TOP = '1;
  localparam int PAD = DW - CW;

  logic [CW-1:0]          cnt_q, reload_q, cap_q;
  logic [NCH-1:0][CW-1:0] duty_q, sduty_q;
  logic [NCH-1:0]         oe_q, pol_q, spol_q, brk_pat_q;
  logic                   cap_fall_q, xfer_q, brk_en_q, brk_act_q, ovf_f_q, cap_f_q;
  logic [1:0]             brk_s;
  logic [2:0]             cap_s;

  wire ovf_ev   = cnt_en && (cnt_q == TOP);
  wire xfer_ev  = ovf_ev && xfer_q;
  wire wr_brk   = wr_en && addr == 4'd3;
  wire wr_stat  = wr_en && addr == 4'd4;
  wire cap_edge = cap_fall_q ? (cap_s[2] & ~cap_s[1]) : (~cap_s[2] & cap_s[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; reload_q <= '0; cap_q <= '0;
      duty_q <= '0; sduty_q <= '0;
      oe_q <= '0; pol_q <= '0; spol_q <= '0; brk_pat_q <= '0;
      cap_fall_q <= 1'b0; xfer_q <= 1'b1; brk_en_q <= 1'b0;
      brk_act_q <= 1'b0; ovf_f_q <= 1'b0; cap_f_q <= 1'b0;
      brk_s <= '0; cap_s <= '0;
    end else begin
      brk_s <= {brk_s[0], brk_in};
      cap_s <= {cap_s[1:0], cap_in};

      if (cnt_en) cnt_q <= (cnt_q == TOP) ? reload_q : cnt_q + 1'b1;

      if (xfer_ev) begin
        sduty_q <= duty_q;
        spol_q  <= pol_q;
        xfer_q  <= 1'b0;
      end

      if (ovf_ev) ovf_f_q <= 1'b1;
      else if (wr_stat && wdata[0]) ovf_f_q <= 1'b0;

      if (cap_edge && !cap_f_q) begin
        cap_q   <= cnt_q;
        cap_f_q <= 1'b1;
      end else if (wr_stat && wdata[1]) cap_f_q <= 1'b0;

      if (brk_en_q && brk_s[1]) brk_act_q <= 1'b1;
      else if (wr_brk && wdata[5]) brk_act_q <= 1'b0;

      if (wr_en) begin
        case (addr)
          4'd0: begin
            oe_q       <= wdata[3:0];
            pol_q      <= wdata[7:4];
            cap_fall_q <= wdata[8];
          end
          4'd1: reload_q <= wdata[CW-1:0];
          4'd2: xfer_q   <= wdata[0];
          4'd3: begin
            brk_pat_q <= wdata[3:0];
            brk_en_q  <= wdata[4];
          end
          4'd8, 4'd9, 4'd10, 4'd11: duty_q[addr[1:0]] <= wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = {7'd0, cap_fall_q, pol_q, oe_q};
      4'd1:    rdata = {{PAD{1'b0}}, reload_q};
      4'd2:    rdata = {{(DW-1){1'b0}}, xfer_q};
      4'd3:    rdata = {10'd0, brk_act_q, brk_en_q, brk_pat_q};
      4'd4:    rdata = {14'd0, cap_f_q, ovf_f_q};
      4'd5:    rdata = {{PAD{1'b0}}, cnt_q};
      4'd6:    rdata = {{PAD{1'b0}}, cap_q};
      4'd8, 4'd9, 4'd10, 4'd11: rdata = {{PAD{1'b0}}, duty_q[addr[1:0]]};
      default: rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire raw = oe_q[i] ? (cnt_q < sduty_q[i]) : (cnt_q == sduty_q[i]);
    assign pwm_out[i] = brk_act_q ? brk_pat_q[i] : (raw ^ spol_q[i]);
  end
endmodule

// File: rtl/pwm4_shadow_timer_chk.sv
module pwm4_shadow_timer_chk #(
  parameter int CW  = 12,
  parameter int NCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_en,
  input logic               wr_en,
  input logic [3:0]         addr,
  input logic [1:0]         wbits,
  input logic [CW-1:0]      cnt_q,
  input logic [CW-1:0]      reload_q,
  input logic               xfer_q,
  input logic [NCH*CW-1:0]  sduty,
  input logic               brk_act_q,
  input logic [NCH-1:0]     brk_pat_q,
  input logic [3:0]         pwm_out,
  input logic               cap_f_q,
  input logic [CW-1:0]      cap_q
);
  localparam logic [CW-1:0] TOP = '1;

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && cnt_q == TOP |=> cnt_q == $past(reload_q));

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && cnt_q == TOP && xfer_q && !(wr_en && addr == 4'd2) |=> !xfer_q);

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && cnt_q == TOP && xfer_q) |=> $stable(sduty));

  a_r7_break_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    brk_act_q |-> pwm_out == brk_pat_q);

  a_r10_capture_refused: assert property (@(posedge clk) disable iff (!rst_n)
    cap_f_q && !(wr_en && addr == 4'd4 && wbits[1]) |=> $stable(cap_q));
endmodule

bind pwm4_shadow_timer pwm4_shadow_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
  .wbits(wdata[1:0]), .cnt_q(cnt_q), .reload_q(reload_q), .xfer_q(xfer_q),
  .sduty(sduty_q), .brk_act_q(brk_act_q), .brk_pat_q(brk_pat_q),
  .pwm_out(pwm_out), .cap_f_q(cap_f_q), .cap_q(cap_q)
);

// File: tb/pwm4_shadow_timer_bench.sv
module pwm4_shadow_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, wr_en = 1'b0, brk_in = 1'b0, cap_in = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pwm_out;

  always #5 clk = ~clk;

  pwm4_shadow_timer u_pwm4_shadow_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .brk_in(brk_in), .cap_in(cap_in), .pwm_out(pwm_out)
  );

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;
  int    checks = 0, errors = 0;

  initial forever begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = it.is_rd ? rdata : {12'd0, pwm_out};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(input bit rd, input logic [3:0] a, input logic [15:0] e, input string req);
    item_t it;
    addr = a;
    it.is_rd = rd; it.exp = e; it.req = req;
    #1;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
    @(negedge clk);
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [15:0] e, input string req);
    push(1'b1, a, e, req);
  endtask

  task automatic exp_pwm(input logic [3:0] e, input string req);
    push(1'b0, 4'd0, {12'd0, e}, req);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    exp_pwm(4'hF, "R11 R4 reset outputs match zero shadows");
    exp_rd(4'd2, 16'h0001, "R11 transfer bit set");
    exp_rd(4'd3, 16'h0000, "R11 break regs");
    exp_rd(4'd6, 16'h0000, "R11 capture reg");
    exp_rd(4'd8, 16'h0000, "R11 duty0");
    exp_rd(4'd5, 16'h0000, "R1 count reset");

    wr(4'd1, 16'h0FF0);
    wr(4'd0, 16'h004F);
    wr(4'd8, 16'hFFFF);
    exp_rd(4'd8, 16'h0FFF, "R2 reserved bits");
    wr(4'd8, 16'h0FF4);
    wr(4'd9, 16'h0FF0);
    wr(4'd10, 16'h0FF8);
    wr(4'd11, 16'h0FFF);
    exp_rd(4'd5, 16'h0000, "R1 hold while disabled");
    exp_pwm(4'h0, "R6 shadows not loaded before wrap");

    step(4095);
    exp_rd(4'd5, 16'h0FFF, "R1 count to top");
    exp_rd(4'd4, 16'h0000, "R1 no overflow yet");
    exp_pwm(4'h0, "R5 old shadows at top");
    step(1);
    exp_rd(4'd5, 16'h0FF0, "R1 reload");
    exp_rd(4'd4, 16'h0001, "R1 overflow flag");
    exp_rd(4'd2, 16'h0000, "R5 transfer bit cleared");
    exp_pwm(4'b1001, "R3 R5 first count of new period");
    step(4);
    exp_pwm(4'b1000, "R3 at ff4");
    step(4);
    exp_pwm(4'b1100, "R3 at ff8 inverted ch2");

    wr(4'd8, 16'h0FF2);
    wr(4'd0, 16'h000F);
    step(7);
    exp_pwm(4'b0100, "R6 staged values unused at fff");
    step(3);
    exp_pwm(4'b1001, "R6 no transfer at wrap");
    exp_rd(4'd8, 16'h0FF2, "R2 staged duty");

    wr(4'd2, 16'h0001);
    exp_rd(4'd2, 16'h0001, "R5 transfer armed");
    step(14);
    exp_rd(4'd2, 16'h0000, "R5 transfer cleared again");
    step(2);
    exp_pwm(4'b1100, "R5 new duty and polarity applied");

    wr(4'd0, 16'h0000);
    exp_pwm(4'b0001, "R4 compare match ch0");
    step(6);
    exp_pwm(4'b0100, "R4 compare match ch2");
    wr(4'd0, 16'h000F);
    exp_pwm(4'b1000, "R3 back to pwm mode");

    wr(4'd3, 16'h000A);
    brk_in = 1'b1;
    idle(4);
    exp_pwm(4'b1000, "R8 break disabled no effect");
    exp_rd(4'd3, 16'h000A, "R8 break not active");
    brk_in = 1'b0;
    idle(4);
    wr(4'd3, 16'h001A);
    brk_in = 1'b1;
    idle(4);
    exp_pwm(4'b1010, "R7 break pattern");
    exp_rd(4'd3, 16'h003A, "R7 break active");
    brk_in = 1'b0;
    idle(4);
    exp_pwm(4'b1010, "R7 break sticky");
    wr(4'd3, 16'h003A);
    exp_pwm(4'b1000, "R7 break cleared");
    exp_rd(4'd3, 16'h001A, "R7 break active bit cleared");
    wr(4'd3, 16'h0000);

    cap_in = 1'b1;
    idle(4);
    exp_rd(4'd6, 16'h0FF8, "R9 rising capture");
    exp_rd(4'd4, 16'h0003, "R9 capture flag");
    step(2);
    cap_in = 1'b0; idle(4);
    cap_in = 1'b1; idle(4);
    exp_rd(4'd6, 16'h0FF8, "R10 capture refused");
    wr(4'd4, 16'h0002);
    exp_rd(4'd4, 16'h0001, "R10 flag cleared");
    cap_in = 1'b0; idle(4);
    cap_in = 1'b1; idle(4);
    exp_rd(4'd6, 16'h0FFA, "R10 re-armed capture");
    wr(4'd0, 16'h010F);
    wr(4'd4, 16'h0002);
    step(1);
    cap_in = 1'b0; idle(4);
    exp_rd(4'd6, 16'h0FFB, "R9 falling capture");
    wr(4'd4, 16'h0001);
    exp_rd(4'd4, 16'h0002, "R1 overflow flag cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule